// File: doc/BRIEF.md
# Switchable GF(2^8) Column Diffusion Unit

This block is the linear mixing layer shared by the two F-function flavours of a four-branch generalized Feistel cipher. It takes one 32-bit column of four bytes and multiplies it, as a column vector, by one of two fixed 4x4 matrices over GF(2^8). A single select input picks the matrix: the first for the even-branch F-function, the second for the odd-branch one. Alternating the two matrices in a fixed pattern is what makes the cipher switch its diffusion from branch to branch.

All constant products are formed from a doubling (xtime) chain and XOR trees, reduced by the polynomial z^8+z^4+z^3+z^2+1 (0x11D). There are no lookup tables. S-boxes and key addition sit outside this block. A parameter adds one output register stage. With it, the result and its valid flag appear one clock after the input. Without it, the unit is purely combinational.

Top module: `dmx_top`

## Requirements
- R1: Every doubling step shifts the byte left by one and, when the bit shifted out was 1, XORs 0x1D into the result. That is reduction by 0x11D. For example, column {80,00,00,00} with select 0 gives {80,1D,3A,27}.
- R2: With `sel_odd` = 0, output byte i is the XOR over j of c0[i xor j]·Y[j], where c0 = {01,02,04,06}.
- R3: With `sel_odd` = 1, output byte i is the XOR over j of c1[i xor j]·Y[j], where c1 = {01,08,02,0A}. For example, {80,00,00,00} gives {80,74,1D,69}.
- R4: Byte 0 (Y0 and Z0) occupies bits 31:24 of `col_in` and `col_out`, and byte 3 occupies bits 7:0.
- R5: With `REG_OUT` = 1, `col_out` and `out_valid` take their values one clock edge after `in_valid` and `col_in` are presented. `out_valid` equals `in_valid` delayed by one cycle.
- R6: With `REG_OUT` = 1, a cycle with `in_valid` low leaves `col_out` unchanged at the next edge.
- R7: A clock edge with `rst_n` low clears `out_valid` and `col_out` to zero. Reset is synchronous.
- R8: A column whose four bytes are all equal is returned unchanged under either matrix, because every row of each matrix XORs to 01.
- R9: An all-zero column produces an all-zero result under either matrix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `col_in` and `sel_odd` |
| sel_odd | input | 1 | Selects the matrix: 0 = first (c0), 1 = second (c1) |
| col_in | input | 32 | Input column, Y0 in bits 31:24 |
| out_valid | output | 1 | Qualifies `col_out` |
| col_out | output | 32 | Mixed column, Z0 in bits 31:24 |

## Verification
A fault in the doubling chain shows up at the port in the cycle after the faulty byte is applied, but only when that byte has its top bit set. The directed columns therefore put 0x80 and 0xFF into every lane. A swapped matrix or a wrong lane index corrupts up to three output bytes of the next result, and single-lane columns reveal it under both select values. A broken hold or valid path is seen on the first idle cycle after a transfer. A behavioural shift-and-add model compares every cycle, so the first divergence is reported at the cycle where it occurs.

// File: rtl/dmx_pkg.sv
// Package dmx_pkg
// Shared widths and the single-step GF(2^8) doubling used by every multiplier.
// Assumes the field polynomial z^8+z^4+z^3+z^2+1, whose low byte is 0x1D.
package dmx_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int COL_W  = BYTE_W * LANES;
    localparam logic [BYTE_W-1:0] RED_LOW = 8'h1D;

    typedef logic [BYTE_W-1:0] byte_t;

    // Multiply one byte by the field element 02.
    function automatic byte_t gf_dbl(input byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_LOW : '0);
    endfunction
endpackage

// File: rtl/dmx_dbl_chain.sv
// Module dmx_dbl_chain
// Produces the products of one byte with 02, 04 and 08 by chaining doublings.
// Purely combinational. Assumes DEPTH >= 1. Output index k holds byte * 2^(k+1).
module dmx_dbl_chain
    import dmx_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  byte_t             b_in,
    output byte_t [DEPTH-1:0] b_pow
);
    byte_t stage [DEPTH+1];

    assign stage[0] = b_in;

    genvar k;
    generate
        for (k = 0; k < DEPTH; k++) begin : g_step
            // Each step doubles the previous product.
            assign stage[k+1] = gf_dbl(stage[k]);
            assign b_pow[k]   = stage[k+1];
        end
    endgenerate
endmodule

// File: rtl/dmx_row.sv
// Module dmx_row
// Computes one output byte of the selected matrix-vector product.
// Both matrices satisfy coef(i,j) = c[i xor j] with c[0] = 01, so row ROW needs
// the lanes ROW^1, ROW^2 and ROW^3 scaled by per-matrix constants.
// Assumes x2/x4/x8 are the doubling-chain products of the matching lanes.
module dmx_row
    import dmx_pkg::*;
#(
    parameter int ROW = 0
) (
    input  logic              sel_odd,
    input  byte_t [LANES-1:0] y,
    input  byte_t [LANES-1:0] x2,
    input  byte_t [LANES-1:0] x4,
    input  byte_t [LANES-1:0] x8,
    output byte_t             z
);
    localparam int P1 = ROW ^ 1;
    localparam int P2 = ROW ^ 2;
    localparam int P3 = ROW ^ 3;

    byte_t t1, t2, t3;

    // Picks the scaled lane for each off-diagonal position of the row.
    always_comb begin
        if (sel_odd) begin
            t1 = x8[P1];
            t2 = x2[P2];
            t3 = x8[P3] ^ x2[P3];
        end else begin
            t1 = x2[P1];
            t2 = x4[P2];
            t3 = x4[P3] ^ x2[P3];
        end
    end

    assign z = y[ROW] ^ t1 ^ t2 ^ t3;
endmodule

// File: rtl/dmx_top.sv
// Module dmx_top
// Switchable diffusion unit: column (4 bytes, byte 0 in the MSBs) times one of
// two fixed GF(2^8) matrices chosen by sel_odd. REG_OUT = 1 adds one output
// register with synchronous active-low reset; REG_OUT = 0 passes through.
module dmx_top
    import dmx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             sel_odd,
    input  logic [COL_W-1:0] col_in,
    output logic             out_valid,
    output logic [COL_W-1:0] col_out
);
    localparam int CHAIN = 3;

    byte_t [LANES-1:0] lane_y, lane_x2, lane_x4, lane_x8, lane_z;
    logic  [COL_W-1:0] mix_col;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            byte_t [CHAIN-1:0] pw;

            // Unpacks lane g from the bus; lane 0 is the top byte.
            assign lane_y[g] = col_in[COL_W-1-g*BYTE_W -: BYTE_W];

            dmx_dbl_chain #(.DEPTH(CHAIN)) u_chain (
                .b_in  (lane_y[g]),
                .b_pow (pw)
            );
            assign lane_x2[g] = pw[0];
            assign lane_x4[g] = pw[1];
            assign lane_x8[g] = pw[2];

            dmx_row #(.ROW(g)) u_row (
                .sel_odd (sel_odd),
                .y       (lane_y),
                .x2      (lane_x2),
                .x4      (lane_x4),
                .x8      (lane_x8),
                .z       (lane_z[g])
            );

            // Repacks output lane g into the same byte position.
            assign mix_col[COL_W-1-g*BYTE_W -: BYTE_W] = lane_z[g];
        end

        if (REG_OUT) begin : g_reg
            logic             v_q;
            logic [COL_W-1:0] c_q;

            // Output stage: clear on reset, load on valid, hold otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    c_q <= '0;
                end else begin
                    v_q <= in_valid;
                    if (in_valid) c_q <= mix_col;
                end
            end
            assign out_valid = v_q;
            assign col_out   = c_q;
        end else begin : g_comb
            assign out_valid = in_valid;
            assign col_out   = mix_col;
        end
    endgenerate
endmodule

// File: rtl/dmx_checker.sv
// Module dmx_checker
// Port-level properties of dmx_top, attached by bind below. Assumes the bench
// holds in_valid low while rst_n is low.
module dmx_checker
    import dmx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             sel_odd,
    input logic [COL_W-1:0] col_in,
    input logic             out_valid,
    input logic [COL_W-1:0] col_out
);
    logic uniform_in;
    // Flags a column whose four bytes are identical.
    assign uniform_in = (col_in[31:24] == col_in[23:16]) &&
                        (col_in[23:16] == col_in[15:8])  &&
                        (col_in[15:8]  == col_in[7:0]);

    generate
        if (REG_OUT) begin : g_seq
            a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            a_r5_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(col_out));
            a_r7_reset_clears: assert property (@(posedge clk)
                !rst_n |=> (!out_valid && col_out == '0));
            a_r8_uniform_passes: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && uniform_in) |=> col_out == $past(col_in));
            a_r9_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && col_in == '0) |=> col_out == '0);
        end else begin : g_cmb
            a_r8_uniform_passes: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && uniform_in) |-> col_out == col_in);
            a_r9_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && col_in == '0) |-> col_out == '0);
            a_r5_valid_passes: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid);
            a_r2_known_output: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> !$isunknown(col_out));
        end
    endgenerate
endmodule

bind dmx_top dmx_checker #(.REG_OUT(REG_OUT)) u_dmx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sel_odd   (sel_odd),
    .col_in    (col_in),
    .out_valid (out_valid),
    .col_out   (col_out)
);

// File: tb/tb_dmx_top.sv
// Bench for dmx_top (REG_OUT = 1). The reference is a behavioural shift-and-add
// GF multiply and a register model updated every cycle.
module tb_dmx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        sel_odd = 1'b0;
    logic [31:0] col_in = '0;
    logic        out_valid;
    logic [31:0] col_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic        exp_valid = 1'b0;
    logic [31:0] exp_col = '0;
    string       exp_tag = "R7";

    always #4 clk = ~clk;

    dmx_top #(.REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_odd(sel_odd),
        .col_in(col_in), .out_valid(out_valid), .col_out(col_out)
    );

    function automatic int gmul(input int a, input int b);
        int p = 0;
        int x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = x << 1;
            if (x & 'h100) x ^= 'h11D;
        end
        return p & 'hFF;
    endfunction

    function automatic logic [31:0] ref_mix(input logic [31:0] c, input bit s);
        int cf0 [4] = '{1, 2, 4, 6};
        int cf1 [4] = '{1, 8, 2, 10};
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            int acc = 0;
            for (int j = 0; j < 4; j++) begin
                int yj = c[31-8*j -: 8];
                acc ^= gmul(s ? cf1[i ^ j] : cf0[i ^ j], yj);
            end
            r[31-8*i -: 8] = acc[7:0];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: compare the registered state, then drive and advance the model.
    task automatic step(input bit v, input bit s, input logic [31:0] c, input string tag);
        @(negedge clk);
        check("R5", {31'b0, out_valid}, {31'b0, exp_valid});
        check(exp_tag, col_out, exp_col);
        in_valid = v; sel_odd = s; col_in = c;
        exp_valid = v;
        if (v) begin
            exp_col = ref_mix(c, s);
            exp_tag = tag;
        end else begin
            exp_tag = "R6";
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7", {31'b0, out_valid}, 32'h0);
        check("R7", col_out, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 / R4: top-bit byte in lane 0 exercises reduction by 0x1D.
        step(1, 0, 32'h8000_0000, "R1");
        step(0, 0, 32'h0, "R6");
        if (ref_mix(32'h8000_0000, 0) !== 32'h801D_3A27) begin
            n_bad++; $display("FAIL R1 model %h expected 801d3a27", ref_mix(32'h8000_0000, 0));
        end
        if (col_out !== 32'h801D_3A27) begin
            n_bad++; $display("FAIL R1 actual=%h expected=801d3a27", col_out);
        end
        n_vec++;
        step(1, 1, 32'h8000_0000, "R3");
        step(0, 1, 32'hDEAD_BEEF, "R6");
        if (col_out !== 32'h8074_1D69) begin
            n_bad++; $display("FAIL R3 actual=%h expected=80741d69", col_out);
        end
        n_vec++;
        // R4: single lane in the bottom byte.
        step(1, 0, 32'h0000_0001, "R4");
        step(1, 1, 32'h0000_00FF, "R4");
        // R2 / R3 per lane, both selects.
        for (int l = 0; l < 4; l++) begin
            step(1, 0, 32'h80 << (8*l), "R2");
            step(1, 1, 32'h80 << (8*l), "R3");
        end
        // R8 uniform, R9 zero.
        step(1, 0, 32'h5A5A_5A5A, "R8");
        step(1, 1, 32'hFFFF_FFFF, "R8");
        step(1, 0, 32'h0, "R9");
        step(1, 1, 32'h0, "R9");
        // Idle gaps then resume (R6).
        step(1, 1, 32'h0123_4567, "R3");
        step(0, 0, 32'hFFFF_0000, "R6");
        step(0, 1, 32'h1234_5678, "R6");
        // Random mix of valid/idle and both matrices.
        for (int k = 0; k < 2000; k++) begin
            bit v = ($urandom_range(0, 3) != 0);
            bit s = $urandom_range(0, 1);
            step(v, s, $urandom, s ? "R3" : "R2");
        end
        // Mid-stream reset (R7).
        @(negedge clk);
        in_valid = 1'b1; col_in = 32'hCAFE_F00D; rst_n = 1'b0;
        @(negedge clk);
        check("R7", {31'b0, out_valid}, 32'h0);
        check("R7", col_out, 32'h0);
        in_valid = 1'b0; rst_n = 1'b1;
        exp_valid = 1'b0; exp_col = '0; exp_tag = "R7";
        step(1, 0, 32'h1111_2222, "R2");
        step(0, 0, 32'h0, "R6");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule